// File: doc/BRIEF.md
# CAN Arbitration Field Transmitter

This block drives the opening of a CAN frame onto a wired-AND bus and decides, bit by bit, whether the node keeps the bus. Logic 0 is the dominant level and logic 1 is the recessive level. The bus reads 0 if any node drives 0, and it reads 1 only when every node drives 1. The block sees the bus only at logic level, through `rx_i`. Once per bit time, `bit_tick_i` marks the sample point. On that strobe the block compares the level it read back with the bit it is driving, and then moves `tx_o` on to the next bit.

A start request carries an 11-bit identifier and a frame-kind select. The block holds the request pending until it sees a recessive bus at a strobe. It then sends 13 arbitration bits, in this order:
1. one dominant start bit;
2. the identifier, most significant bit first, so a lower identifier wins;
3. the request bit: 0 for a data frame, 1 for a remote frame. A data frame therefore beats a remote frame with the same identifier.

If the node drives recessive and reads back dominant, it has lost arbitration. It goes quiet, raises `lost_o` and records the bit index. If it drives dominant and reads back recessive, it flags a bit error and stops. If all 13 bits match, it pulses `won_o` for one bit time. Whatever logic sends the rest of the frame can then take over.

Top module: `can_arb_tx`

## Requirements
- R1: After reset, `tx_o` is 1 (recessive) and `busy_o`, `won_o`, `lost_o`, `bit_err_o` and `lost_idx_o` are all 0.
- R2: A start request is accepted only at a `bit_tick_i` at which `rx_i` is 1 and the previous `IDLE_BITS-1` strobes also saw 1. The default `IDLE_BITS` is 1. Until then the request stays pending and `tx_o` stays 1. A `start_i` that falls in the strobe cycle itself is accepted at that strobe.
- R3: After acceptance, `tx_o` carries 13 bits, each for exactly one bit time, and changes only in the cycle after a strobe. Bit index 0 is a 0. Indices 1 to 11 are `id_i[10]` down to `id_i[0]`. Index 12 is `remote_i` (0 for a data frame, 1 for a remote frame). The identifier and select are captured with the request.
- R4: At a strobe where the block drives 1 and `rx_i` reads 0:
  - `lost_o` goes to 1;
  - `lost_idx_o` takes the bit index (numbered as in R3);
  - `tx_o` stays 1 from then on.
  Both outputs hold until the next accepted start.
- R5: When two nodes send the same identifier, the data frame (request bit 0) wins. The remote frame loses at index 12.
- R6: If all 13 bits match, `won_o` is 1 from the strobe that ends index 12 until the next strobe. `lost_o` and `bit_err_o` stay 0 while it is high.
- R7: At a strobe where the block drives 0 and `rx_i` reads 1:
  - `bit_err_o` goes to 1;
  - `tx_o` returns to 1;
  - `busy_o` drops.
  `bit_err_o` holds until the next accepted start.
- R8: A `start_i` while `busy_o` is 1 is ignored. The frame in progress is unchanged, and no frame follows it.
- R9: `busy_o` is 1 from acceptance until the strobe that ends arbitration by win, loss or bit error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle strobe at each bit sample point |
| start_i | input | 1 | Request to begin a frame |
| id_i | input | ID_W | Identifier to send |
| remote_i | input | 1 | 1 for a remote frame, 0 for a data frame |
| rx_i | input | 1 | Bus level read back |
| tx_o | output | 1 | Bit driven to the bus |
| busy_o | output | 1 | Arbitration in progress |
| won_o | output | 1 | Arbitration won, held for one bit time |
| lost_o | output | 1 | Arbitration lost |
| lost_idx_o | output | IDX_W | Bit index at which arbitration was lost |
| bit_err_o | output | 1 | Dominant bit read back as recessive |

## Verification
Two decisions fall on the same strobe at the end of the request bit: raising `won_o` and raising `lost_o`. The bench provokes this by contending a remote frame against a data frame with the same identifier. It judges that only the loss appears, at index 12, with `won_o` low, and it runs the reverse pairing to see the data frame win on that same strobe. It also lands a start request in the strobe cycle itself on a free bus. It expects the start bit in the very next cycle, with no bit time spent pending.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ARB  = 1'b1
  } arb_state_e;

  localparam logic LVL_DOM = 1'b0;
  localparam logic LVL_REC = 1'b1;
endpackage

// File: rtl/can_idle_mon.sv
module can_idle_mon #(
  parameter int IDLE_BITS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic rx_i,
  output logic bus_free_o
);
  localparam int CW = $clog2(IDLE_BITS + 1);

  logic [CW-1:0] cnt_q;

  // recessive strobes seen before this one; the current strobe counts too
  assign bus_free_o = rx_i && (({1'b0, cnt_q} + 1'b1) >= (CW+1)'(IDLE_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (bit_tick_i) begin
      if (!rx_i)                        cnt_q <= '0;
      else if (cnt_q != CW'(IDLE_BITS)) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/can_arb_frame.sv
module can_arb_frame #(
  parameter int ID_W  = 11,
  parameter int NBITS = ID_W + 2,
  parameter int IDX_W = $clog2(NBITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic             remote_i,
  input  logic [IDX_W-1:0] sel_i,
  output logic             bit_o
);
  import can_arb_pkg::*;

  logic [NBITS-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        frame_q <= '1;
    else if (capture_i) frame_q <= {LVL_DOM, id_i, remote_i};
  end

  // index 0 sits at the MSB so the identifier leaves MSB first
  always_comb begin
    bit_o = LVL_REC;
    for (int i = 0; i < NBITS; i++) begin
      if (sel_i == IDX_W'(i)) bit_o = frame_q[NBITS-1-i];
    end
  end
endmodule

// File: rtl/can_arb_cmp.sv
module can_arb_cmp (
  input  logic drv_i,
  input  logic bus_i,
  output logic lost_o,
  output logic err_o
);
  assign lost_o = drv_i  & ~bus_i;
  assign err_o  = ~drv_i &  bus_i;
endmodule

// File: rtl/can_arb_tx.sv
module can_arb_tx #(
  parameter int ID_W      = 11,
  parameter int IDLE_BITS = 1,
  parameter int NBITS     = ID_W + 2,
  parameter int IDX_W     = $clog2(NBITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_tick_i,
  input  logic             start_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic             remote_i,
  input  logic             rx_i,
  output logic             tx_o,
  output logic             busy_o,
  output logic             won_o,
  output logic             lost_o,
  output logic [IDX_W-1:0] lost_idx_o,
  output logic             bit_err_o
);
  import can_arb_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBITS - 1);

  arb_state_e       state_q;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic             tx_q, pend_q, won_q, lost_q, err_q;
  logic [IDX_W-1:0] lost_idx_q;
  logic             bus_free, capture, take, nxt_bit, cmp_lost, cmp_err;

  assign capture = start_i && (state_q == ST_IDLE) && !pend_q;
  assign take    = (state_q == ST_IDLE) && (pend_q || start_i) && bit_tick_i && bus_free;
  assign idx_nxt = idx_q + 1'b1;

  can_idle_mon #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_tick_i (bit_tick_i),
    .rx_i       (rx_i),
    .bus_free_o (bus_free)
  );

  can_arb_frame #(.ID_W(ID_W), .NBITS(NBITS), .IDX_W(IDX_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .id_i      (id_i),
    .remote_i  (remote_i),
    .sel_i     (idx_nxt),
    .bit_o     (nxt_bit)
  );

  can_arb_cmp u_cmp (
    .drv_i  (tx_q),
    .bus_i  (rx_i),
    .lost_o (cmp_lost),
    .err_o  (cmp_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      tx_q       <= LVL_REC;
      pend_q     <= 1'b0;
      won_q      <= 1'b0;
      lost_q     <= 1'b0;
      err_q      <= 1'b0;
      lost_idx_q <= '0;
    end else begin
      if (won_q && bit_tick_i) won_q <= 1'b0;
      if (capture) pend_q <= 1'b1;
      if (take) begin
        state_q    <= ST_ARB;
        idx_q      <= '0;
        tx_q       <= LVL_DOM;
        pend_q     <= 1'b0;
        lost_q     <= 1'b0;
        err_q      <= 1'b0;
        lost_idx_q <= '0;
      end else if (state_q == ST_ARB && bit_tick_i) begin
        if (cmp_lost) begin
          lost_q     <= 1'b1;
          lost_idx_q <= idx_q;
          tx_q       <= LVL_REC;
          state_q    <= ST_IDLE;
        end else if (cmp_err) begin
          err_q   <= 1'b1;
          tx_q    <= LVL_REC;
          state_q <= ST_IDLE;
        end else if (idx_q == LAST_IDX) begin
          won_q   <= 1'b1;
          tx_q    <= LVL_REC;
          state_q <= ST_IDLE;
        end else begin
          idx_q <= idx_nxt;
          tx_q  <= nxt_bit;
        end
      end
    end
  end

  assign tx_o       = tx_q;
  assign busy_o     = (state_q == ST_ARB);
  assign won_o      = won_q;
  assign lost_o     = lost_q;
  assign lost_idx_o = lost_idx_q;
  assign bit_err_o  = err_q;
endmodule

// File: rtl/can_arb_tx_chk.sv
module can_arb_tx_chk #(
  parameter int NBITS = 13,
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_tick_i,
  input logic             tx_o,
  input logic             busy_o,
  input logic             won_o,
  input logic             lost_o,
  input logic [IDX_W-1:0] lost_idx_o,
  input logic             bit_err_o
);
  assert_idle_recessive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);

  assert_tx_moves_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> $stable(tx_o));

  assert_lost_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> (tx_o && !busy_o));

  assert_lost_idx_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> (lost_idx_o <= IDX_W'(NBITS - 1)));

  assert_won_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({won_o, lost_o, bit_err_o}));

  assert_won_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (won_o && !bit_tick_i) |=> won_o);

  assert_won_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (won_o && bit_tick_i) |=> !won_o);

  assert_err_stops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bit_err_o) |-> (tx_o && !busy_o));

  assert_busy_ends_on_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(bit_tick_i));
endmodule

bind can_arb_tx can_arb_tx_chk #(.NBITS(NBITS), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_tick_i (bit_tick_i),
  .tx_o       (tx_o),
  .busy_o     (busy_o),
  .won_o      (won_o),
  .lost_o     (lost_o),
  .lost_idx_o (lost_idx_o),
  .bit_err_o  (bit_err_o)
);

// File: tb/can_arb_tx_bench.sv
`timescale 1ns/1ps
module can_arb_tx_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [10:0] id_i = '0;
  logic        remote_i = 1'b0;
  logic        other = 1'b1;
  logic        force_rec = 1'b0;
  logic [1:0]  tcnt = '0;
  logic        bit_tick_i;
  logic        rx_i;
  logic        tx_o, busy_o, won_o, lost_o, bit_err_o;
  logic [3:0]  lost_idx_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #5 clk_i = ~clk_i;

  always_ff @(posedge clk_i) tcnt <= tcnt + 1'b1;
  assign bit_tick_i = (tcnt == 2'd3);
  assign rx_i = (tx_o & other) | force_rec;

  can_arb_tx u_can_arb_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_tick_i (bit_tick_i),
    .start_i    (start_i),
    .id_i       (id_i),
    .remote_i   (remote_i),
    .rx_i       (rx_i),
    .tx_o       (tx_o),
    .busy_o     (busy_o),
    .won_o      (won_o),
    .lost_o     (lost_o),
    .lost_idx_o (lost_idx_o),
    .bit_err_o  (bit_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // returns 1ns after the clock edge on which a strobe is sampled
  task automatic wait_tick();
    do @(negedge clk_i); while (!bit_tick_i);
    @(posedge clk_i);
    #1;
  endtask

  task automatic request_start(input logic [10:0] id, input logic rem, input bit on_tick);
    id_i = id;
    remote_i = rem;
    if (on_tick) begin
      do @(negedge clk_i); while (!bit_tick_i);
      start_i = 1'b1;
      @(posedge clk_i);
      #1 start_i = 1'b0;
    end else begin
      do @(negedge clk_i); while (bit_tick_i);
      start_i = 1'b1;
      @(posedge clk_i);
      #1 start_i = 1'b0;
      chk(!busy_o && tx_o, "R2", busy_o, 0, "pending request must not start before a strobe");
      wait_tick();
    end
  endtask

  task automatic run_frame(input logic [10:0] my_id, input logic my_rem, input bit oth_on,
                           input logic [10:0] oth_id, input logic oth_rem,
                           input bit on_tick, input bit poke_busy, input string req);
    logic [12:0] mb, ob;
    int lost_at;
    mb = {1'b0, my_id, my_rem};
    ob = {1'b0, oth_id, oth_rem};
    lost_at = -1;
    for (int k = 0; k < 13; k++) begin
      logic bus;
      bus = mb[12-k] & (oth_on ? ob[12-k] : 1'b1);
      if (lost_at < 0 && mb[12-k] && !bus) lost_at = k;
    end
    other = 1'b1;
    wait_tick();
    wait_tick();
    request_start(my_id, my_rem, on_tick);
    if (oth_on) other = ob[12];
    chk(busy_o, "R9", busy_o, 1, "busy after acceptance");
    chk(!lost_o && !bit_err_o, "R4", lost_o, 0, "status cleared by new start");
    for (int k = 0; k < 13; k++) begin
      logic exp;
      exp = (lost_at >= 0 && k > lost_at) ? 1'b1 : mb[12-k];
      chk(tx_o == exp, (lost_at >= 0 && k > lost_at) ? "R4" : req, tx_o, exp, $sformatf("tx bit %0d", k));
      if (poke_busy && k == 5) begin
        @(negedge clk_i);
        start_i = 1'b1;
        id_i = ~my_id;
        remote_i = ~my_rem;
        @(negedge clk_i);
        start_i = 1'b0;
      end
      wait_tick();
      other = (oth_on && k < 12) ? ob[11-k] : 1'b1;
      if (k == lost_at) begin
        chk(lost_o, "R4", lost_o, 1, "lost flag");
        chk(lost_idx_o == 4'(k), "R4", lost_idx_o, k, "lost index");
        chk(tx_o && !busy_o, "R4", tx_o, 1, "recessive after loss");
      end
    end
    chk(won_o == (lost_at < 0), (lost_at == 12) ? "R5" : "R6", won_o, lost_at < 0, "won at end");
    if (lost_at < 0) chk(!lost_o && !busy_o, "R9", busy_o, 0, "busy ends on win");
    wait_tick();
    chk(!won_o, "R6", won_o, 0, "won lasts one bit time");
    if (poke_busy) begin
      wait_tick();
      wait_tick();
      chk(tx_o && !busy_o, "R8", busy_o, 0, "no frame from request while busy");
    end
  endtask

  task automatic t_reset();
    chk(tx_o && !busy_o && !won_o && !lost_o && !bit_err_o && lost_idx_o == 0,
        "R1", {tx_o, busy_o, won_o, lost_o, bit_err_o}, 5'b10000, "reset state");
  endtask

  task automatic t_pending();
    other = 1'b0;
    wait_tick();
    request_start(11'h2A5, 1'b0, 1'b0);
    chk(!busy_o && tx_o, "R2", busy_o, 0, "held while bus dominant (1)");
    wait_tick();
    chk(!busy_o && tx_o, "R2", busy_o, 0, "held while bus dominant (2)");
    other = 1'b1;
    wait_tick();
    chk(busy_o && !tx_o, "R2", tx_o, 0, "start bit after first recessive strobe");
    for (int k = 0; k < 13; k++) wait_tick();
    chk(won_o, "R6", won_o, 1, "pending frame wins alone");
    wait_tick();
  endtask

  task automatic t_bit_error();
    other = 1'b1;
    wait_tick();
    request_start(11'h0F0, 1'b0, 1'b0);
    force_rec = 1'b1;
    wait_tick();
    force_rec = 1'b0;
    chk(bit_err_o, "R7", bit_err_o, 1, "bit error flag");
    chk(tx_o && !busy_o && !lost_o, "R7", tx_o, 1, "stops after bit error");
    wait_tick();
    chk(bit_err_o && tx_o, "R7", bit_err_o, 1, "bit error holds");
  endtask

  initial begin
    #200000;
    chk(0, "WATCHDOG", 0, 1, "timeout");
    summary();
  end

  initial begin
    #23 rst_ni = 1'b1;
    #2 t_reset();
    run_frame(11'h5A3, 1'b0, 0, 11'h000, 1'b0, 0, 0, "R3");  // solo data frame
    run_frame(11'h123, 1'b0, 1, 11'h122, 1'b0, 0, 0, "R3");  // lose at identifier LSB
    run_frame(11'h100, 1'b1, 1, 11'h300, 1'b1, 0, 0, "R3");  // lower identifier wins
    run_frame(11'h3C7, 1'b1, 1, 11'h3C7, 1'b0, 0, 0, "R5");  // remote vs data, same id
    run_frame(11'h3C7, 1'b0, 1, 11'h3C7, 1'b1, 0, 0, "R5");  // data vs remote, same id
    run_frame(11'h7FF, 1'b1, 1, 11'h000, 1'b0, 1, 0, "R2");  // start in strobe cycle, lose at 1
    run_frame(11'h055, 1'b0, 0, 11'h000, 1'b0, 0, 1, "R8");  // request while busy ignored
    t_pending();
    t_bit_error();
    run_frame(11'h011, 1'b1, 0, 11'h000, 1'b0, 0, 0, "R7");  // bit error cleared by start
    summary();
  end
endmodule